// File: doc/BRIEF.md
# CAN Fault-Confinement Status and Interrupt Monitor

This block sits beside a CAN protocol engine. It receives the engine's transmit and receive error counters and a set of single-cycle pulses, one for each kind of frame error. From these it keeps a status word in which each error cause is latched until software clears it. It also derives the fault-confinement state of the node: error-active, warning, error-passive or bus-off.

When the node enters the warning, error-passive or bus-off state, the block sets an interrupt flag for that state. Each flag can be enabled on its own. The combined request is routed to one of two interrupt lines, and each line has its own enable.

Software reads the status, flag and enable words directly. It clears latched bits by writing ones to them through a single-cycle register write strobe. The counter rules and the protocol engine itself are outside this block.

Top module: `canFaultMonitor`

## Requirements
- R1: After reset, the status, flag and enable words all read zero and both interrupt lines are low.
- R2: A pulse on cause input k sets status bit 19+k on the next clock edge, and the bit stays set. The cause inputs, from bit 0 upward, are: acknowledge, stuff, CRC, stuck-dominant, bit and form error, which gives status bits 19 to 24.
- R3: A status write (select 0) clears each cause bit whose data bit is 1 and leaves bits written with 0 unchanged. A pulse in the same cycle as the clear wins, so the bit stays set.
- R4: The state bits show the state one edge after the counters change. Status bit 18 means bus-off (transmit counter at least 256). Bit 17 means error-passive (either counter at least 128). Bit 16 means warning (either counter at least 96). Only the highest-priority state bit is set, and none is set in the error-active state.
- R5: Writing 1s to status bits 16 to 18 has no effect; those bits always follow the counters.
- R6: Flag bits 8 (warning), 9 (error-passive) and 10 (bus-off) set only on the edge where their state is entered. Staying in a state does not set the flag again after it has been cleared.
- R7: A flag write (select 1) clears each flag whose data bit is 1. A state entry in the same cycle as the clear wins, so the flag stays set.
- R8: An enable write (select 2) loads bits 0 (line-0 enable), 1 (line-1 enable), 2 (route to line 1) and 8 to 10 (per-flag enables). All other bits read 0.
- R9: The request is the OR of the flags ANDed with their enables. Line 0 carries the request when route is 0 and the line-0 enable is set. Line 1 carries it when route is 1 and the line-1 enable is set. Both lines are combinational from the registers.
- R10: A receive counter of 256 or more, with a transmit counter below 256, gives error-passive and never bus-off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txErrCnt | input | 9 | Transmit error counter from the protocol engine |
| rxErrCnt | input | 9 | Receive error counter from the protocol engine |
| errEvt | input | 6 | Single-cycle error-cause pulses (ack, stuff, CRC, stuck, bit, form) |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 2 | Write target: 0 status, 1 flags, 2 enables |
| regWrData | input | 32 | Write data (write-1-to-clear for status and flags) |
| statusOut | output | 32 | Latched causes and live state bits |
| flagsOut | output | 32 | Interrupt flags in bits 10:8 |
| maskOut | output | 32 | Interrupt enables and line routing |
| irqLine0 | output | 1 | Interrupt line 0 |
| irqLine1 | output | 1 | Interrupt line 1 |

## Verification
A wrong registered state shows on status bits 16 to 18 one edge after the counters move, so any error in threshold decoding or priority is visible within a cycle. A wrong previous-state value shows as a missing or repeated flag, either on the entry edge or after a clear while the counters hold still. A bad latch or a bad clear of a cause or flag shows on the next edge. Faults in routing or enables show on the lines in the same cycle. The reference model is compared against every output on every clock, under both directed sequences and a random phase, so each of these faults is reported within one cycle of its cause.

// File: rtl/canFmPkg.sv
package canFmPkg;

  typedef enum logic [1:0] {
    ST_ACTIVE  = 2'd0,
    ST_WARN    = 2'd1,
    ST_PASSIVE = 2'd2,
    ST_BUSOFF  = 2'd3
  } faultState_e;

  // Strobes from the state control to the register datapath
  typedef struct packed {
    logic enterBusOff;
    logic enterPassive;
    logic enterWarn;
    logic isBusOff;
    logic isPassive;
    logic isWarn;
  } ctrlStrobes_t;

  localparam int NUM_FLAG     = 3;
  localparam int CAUSE_LSB    = 19;
  localparam int STATE_LSB    = 16;
  localparam int FLAG_LSB     = 8;
  localparam int EN_LINE0     = 0;
  localparam int EN_LINE1     = 1;
  localparam int ROUTE_LINE1  = 2;

  localparam logic [1:0] SEL_STATUS = 2'd0;
  localparam logic [1:0] SEL_FLAGS  = 2'd1;
  localparam logic [1:0] SEL_MASK   = 2'd2;

endpackage

// File: rtl/canFmCtrl.sv
module canFmCtrl
  import canFmPkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] txCnt,
  input  logic [CNT_W-1:0] rxCnt,
  output ctrlStrobes_t     strobes
);

  localparam int WIDE_W = CNT_W + 1;
  localparam logic [WIDE_W-1:0] WARN_V    = WIDE_W'(WARN_LIM);
  localparam logic [WIDE_W-1:0] PASSIVE_V = WIDE_W'(PASSIVE_LIM);
  localparam logic [WIDE_W-1:0] BUSOFF_V  = WIDE_W'(BUSOFF_LIM);

  logic [WIDE_W-1:0] txWide, rxWide;
  logic overWarn, overPassive, overBusOff;
  faultState_e stateQ, stateNext;

  assign txWide = {1'b0, txCnt};
  assign rxWide = {1'b0, rxCnt};

  // Threshold decode; only the transmit counter can force bus-off
  always_comb begin
    overBusOff  = (txWide >= BUSOFF_V);
    overPassive = (txWide >= PASSIVE_V) || (rxWide >= PASSIVE_V);
    overWarn    = (txWide >= WARN_V) || (rxWide >= WARN_V);
    if (overBusOff)       stateNext = ST_BUSOFF;
    else if (overPassive) stateNext = ST_PASSIVE;
    else if (overWarn)    stateNext = ST_WARN;
    else                  stateNext = ST_ACTIVE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_ACTIVE;
    else       stateQ <= stateNext;
  end

  always_comb begin
    strobes              = '0;
    strobes.enterWarn    = (stateNext == ST_WARN)    && (stateQ != ST_WARN);
    strobes.enterPassive = (stateNext == ST_PASSIVE) && (stateQ != ST_PASSIVE);
    strobes.enterBusOff  = (stateNext == ST_BUSOFF)  && (stateQ != ST_BUSOFF);
    strobes.isWarn       = (stateQ == ST_WARN);
    strobes.isPassive    = (stateQ == ST_PASSIVE);
    strobes.isBusOff     = (stateQ == ST_BUSOFF);
  end

  // R4: transmit counter at the bus-off limit wins over every other state
  a_r4_busoff_priority: assert property (@(posedge clk) disable iff (!rstN)
    (txWide >= BUSOFF_V) |=> strobes.isBusOff);

  // R10: a high receive counter alone never leads to bus-off
  a_r10_rx_gives_passive: assert property (@(posedge clk) disable iff (!rstN)
    ((txWide < BUSOFF_V) && (rxWide >= BUSOFF_V)) |=> strobes.isPassive);

  // R6: an entry strobe cannot repeat on the following edge
  a_r6_entry_once: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enterBusOff |=> !strobes.enterBusOff);

endmodule

// File: rtl/canFmRegs.sv
module canFmRegs
  import canFmPkg::*;
#(
  parameter int REG_W     = 32,
  parameter int NUM_CAUSE = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStrobes_t         strobes,
  input  logic [NUM_CAUSE-1:0] evtPulse,
  input  logic                 wrEn,
  input  logic [1:0]           wrSel,
  input  logic [REG_W-1:0]     wrData,
  output logic [REG_W-1:0]     statusOut,
  output logic [REG_W-1:0]     flagsOut,
  output logic [REG_W-1:0]     maskOut,
  output logic                 irqLine0,
  output logic                 irqLine1
);

  logic clrStatus, clrFlags, ldMask;
  logic [NUM_CAUSE-1:0] causeQ;
  logic [NUM_FLAG-1:0]  flagQ, flagEnQ, enterVec;
  logic [2:0]           lineCfgQ;
  logic                 irqPending;
  logic                 unusedWrBits;

  assign clrStatus = wrEn && (wrSel == SEL_STATUS);
  assign clrFlags  = wrEn && (wrSel == SEL_FLAGS);
  assign ldMask    = wrEn && (wrSel == SEL_MASK);
  assign enterVec  = {strobes.enterBusOff, strobes.enterPassive, strobes.enterWarn};
  assign unusedWrBits = ^{wrData[REG_W-1:CAUSE_LSB+NUM_CAUSE], wrData[CAUSE_LSB-1:FLAG_LSB+NUM_FLAG],
                          wrData[FLAG_LSB-1:3]};

  // Sticky cause bits: a pulse wins over a clear in the same cycle
  for (genvar gc = 0; gc < NUM_CAUSE; gc++) begin : g_cause
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) causeQ[gc] <= 1'b0;
      else       causeQ[gc] <= evtPulse[gc] |
                               (causeQ[gc] & ~(clrStatus & wrData[CAUSE_LSB+gc]));
    end

    // R2: a cause pulse is visible on the next edge
    a_r2_cause_sets: assert property (@(posedge clk) disable iff (!rstN)
      evtPulse[gc] |=> causeQ[gc]);

    // R3: a latched cause holds unless written with 1
    a_r3_cause_holds: assert property (@(posedge clk) disable iff (!rstN)
      (causeQ[gc] && !(clrStatus && wrData[CAUSE_LSB+gc])) |=> causeQ[gc]);
  end

  // Interrupt flags: set on state entry, write-1-to-clear, entry wins
  for (genvar gf = 0; gf < NUM_FLAG; gf++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flagQ[gf] <= 1'b0;
      else       flagQ[gf] <= enterVec[gf] |
                              (flagQ[gf] & ~(clrFlags & wrData[FLAG_LSB+gf]));
    end

    // R6: a flag only rises after an entry strobe
    a_r6_flag_on_entry: assert property (@(posedge clk) disable iff (!rstN)
      $rose(flagQ[gf]) |-> $past(enterVec[gf]));

    // R7: a set flag stays until cleared by a 1
    a_r7_flag_holds: assert property (@(posedge clk) disable iff (!rstN)
      (flagQ[gf] && !(clrFlags && wrData[FLAG_LSB+gf])) |=> flagQ[gf]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagEnQ  <= '0;
      lineCfgQ <= '0;
    end else if (ldMask) begin
      flagEnQ  <= wrData[FLAG_LSB +: NUM_FLAG];
      lineCfgQ <= wrData[2:0];
    end
  end

  always_comb begin
    statusOut = '0;
    statusOut[CAUSE_LSB +: NUM_CAUSE] = causeQ;
    statusOut[STATE_LSB]   = strobes.isWarn;
    statusOut[STATE_LSB+1] = strobes.isPassive;
    statusOut[STATE_LSB+2] = strobes.isBusOff;
    flagsOut = '0;
    flagsOut[FLAG_LSB +: NUM_FLAG] = flagQ;
    maskOut = '0;
    maskOut[FLAG_LSB +: NUM_FLAG] = flagEnQ;
    maskOut[2:0] = lineCfgQ;
  end

  assign irqPending = |(flagQ & flagEnQ);
  assign irqLine0   = irqPending && !lineCfgQ[ROUTE_LINE1] && lineCfgQ[EN_LINE0];
  assign irqLine1   = irqPending &&  lineCfgQ[ROUTE_LINE1] && lineCfgQ[EN_LINE1];

  // R9: at most one line active, and only with an enabled flag behind it
  a_r9_lines_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(irqLine0 && irqLine1));
  a_r9_line_has_source: assert property (@(posedge clk) disable iff (!rstN)
    (irqLine0 || irqLine1) |-> ((flagQ & flagEnQ) != '0));

endmodule

// File: rtl/canFaultMonitor.sv
module canFaultMonitor
  import canFmPkg::*;
#(
  parameter int CNT_W       = 9,
  parameter int NUM_CAUSE   = 6,
  parameter int REG_W       = 32,
  parameter int WARN_LIM    = 96,
  parameter int PASSIVE_LIM = 128,
  parameter int BUSOFF_LIM  = 256
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [CNT_W-1:0]     txErrCnt,
  input  logic [CNT_W-1:0]     rxErrCnt,
  input  logic [NUM_CAUSE-1:0] errEvt,
  input  logic                 regWrEn,
  input  logic [1:0]           regWrSel,
  input  logic [REG_W-1:0]     regWrData,
  output logic [REG_W-1:0]     statusOut,
  output logic [REG_W-1:0]     flagsOut,
  output logic [REG_W-1:0]     maskOut,
  output logic                 irqLine0,
  output logic                 irqLine1
);

  ctrlStrobes_t strobes;

  canFmCtrl #(
    .CNT_W(CNT_W), .WARN_LIM(WARN_LIM), .PASSIVE_LIM(PASSIVE_LIM), .BUSOFF_LIM(BUSOFF_LIM)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .txCnt(txErrCnt), .rxCnt(rxErrCnt), .strobes(strobes)
  );

  canFmRegs #(.REG_W(REG_W), .NUM_CAUSE(NUM_CAUSE)) i_regs (
    .clk(clk), .rstN(rstN), .strobes(strobes), .evtPulse(errEvt),
    .wrEn(regWrEn), .wrSel(regWrSel), .wrData(regWrData),
    .statusOut(statusOut), .flagsOut(flagsOut), .maskOut(maskOut),
    .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

endmodule

// File: tb/test_canFaultMonitor.sv
`timescale 1ns/1ps
module test_canFaultMonitor;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [8:0] txErrCnt = '0, rxErrCnt = '0;
  logic [5:0] errEvt = '0;
  logic regWrEn = 1'b0;
  logic [1:0] regWrSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] statusOut, flagsOut, maskOut;
  logic irqLine0, irqLine1;

  int checks = 0;
  int errors = 0;
  string curTag = "R1";

  // reference model state
  int mState = 0;
  logic [5:0]  mCause = '0;
  logic [2:0]  mFlags = '0;
  logic [31:0] mMask = '0;

  always #5 clk = ~clk;

  canFaultMonitor i_canFaultMonitor (
    .clk(clk), .rstN(rstN), .txErrCnt(txErrCnt), .rxErrCnt(rxErrCnt), .errEvt(errEvt),
    .regWrEn(regWrEn), .regWrSel(regWrSel), .regWrData(regWrData),
    .statusOut(statusOut), .flagsOut(flagsOut), .maskOut(maskOut),
    .irqLine0(irqLine0), .irqLine1(irqLine1)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (%s) t=%0t actual=%h expected=%h", tag, curTag, $time, act, exp);
    end
  endtask

  // behavioural reference, advanced on every edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mCause = '0; mFlags = '0; mMask = '0;
    end else begin
      int tx, rx, ns;
      tx = int'(txErrCnt); rx = int'(rxErrCnt);
      if (tx >= 256) ns = 3;
      else if (tx >= 128 || rx >= 128) ns = 2;
      else if (tx >= 96 || rx >= 96) ns = 1;
      else ns = 0;
      if (regWrEn && regWrSel == 2'd1) mFlags = mFlags & ~regWrData[10:8];
      if (ns != mState && ns != 0) mFlags[ns-1] = 1'b1;
      mState = ns;
      if (regWrEn && regWrSel == 2'd0) mCause = mCause & ~regWrData[24:19];
      mCause = mCause | errEvt;
      if (regWrEn && regWrSel == 2'd2) mMask = regWrData & 32'h0000_0707;
    end
  end

  function automatic logic [31:0] expStatus();
    logic [31:0] s;
    s = '0;
    s[24:19] = mCause;
    s[16] = (mState == 1);
    s[17] = (mState == 2);
    s[18] = (mState == 3);
    return s;
  endfunction

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      logic pend;
      pend = |(mFlags & mMask[10:8]);
      chk("R2 causes", statusOut & 32'h01F8_0000, expStatus() & 32'h01F8_0000);
      chk("R4 state", statusOut & 32'h0007_0000, expStatus() & 32'h0007_0000);
      chk("R6 flags", flagsOut, {21'b0, mFlags, 8'b0});
      chk("R8 mask", maskOut, mMask);
      chk("R9 line0", {31'b0, irqLine0}, {31'b0, pend & ~mMask[2] & mMask[0]});
      chk("R9 line1", {31'b0, irqLine1}, {31'b0, pend & mMask[2] & mMask[1]});
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] data);
    regWrEn = 1'b1; regWrSel = sel; regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic pulse(input logic [5:0] p);
    errEvt = p;
    @(negedge clk);
    errEvt = '0;
  endtask

  task automatic cnt(input int tx, input int rx);
    txErrCnt = 9'(tx); rxErrCnt = 9'(rx);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int vals[12] = '{0, 50, 95, 96, 100, 127, 128, 200, 255, 256, 300, 511};
    @(negedge clk);
    // R1: reset values while reset is held
    chk("R1 status", statusOut, 32'h0);
    chk("R1 flags", flagsOut, 32'h0);
    chk("R1 mask", maskOut, 32'h0);
    chk("R1 lines", {30'b0, irqLine1, irqLine0}, 32'h0);
    idle(2);
    rstN = 1'b1;
    idle(2);

    curTag = "R2";
    for (int k = 0; k < 6; k++) begin pulse(6'(1 << k)); idle(1); end
    chk("R2 all causes", statusOut & 32'h01F8_0000, 32'h01F8_0000);

    curTag = "R3";
    wr(2'd0, 32'h0);               // zeros: no effect
    wr(2'd0, 32'h0020_0000);       // clear CRC cause (bit 21)
    chk("R3 crc cleared", statusOut & 32'h01F8_0000, 32'h01D8_0000);
    regWrEn = 1'b1; regWrSel = 2'd0; regWrData = 32'h0008_0000; errEvt = 6'b000001;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; errEvt = '0;
    chk("R3 pulse wins", statusOut & 32'h0008_0000, 32'h0008_0000);
    wr(2'd0, 32'hFFFF_FFFF);

    curTag = "R8";
    wr(2'd2, 32'hFFFF_FFFF);
    chk("R8 writable bits", maskOut, 32'h0000_0707);
    wr(2'd2, 32'h0000_0701);

    curTag = "R4";
    cnt(95, 0); cnt(96, 0); cnt(127, 0); cnt(128, 0); cnt(255, 0); cnt(256, 0);
    idle(1);
    chk("R4 busoff bit", statusOut & 32'h0007_0000, 32'h0004_0000);
    cnt(0, 96); cnt(0, 128); cnt(0, 0);

    curTag = "R5";
    cnt(130, 10);
    wr(2'd0, 32'h0007_0000);
    chk("R5 state unchanged", statusOut & 32'h0007_0000, 32'h0002_0000);

    curTag = "R6";
    wr(2'd1, 32'h0000_0700);
    idle(4);
    chk("R6 no re-set while held", flagsOut, 32'h0);
    cnt(0, 0); cnt(100, 0); idle(1);

    curTag = "R7";
    txErrCnt = 9'd140;
    regWrEn = 1'b1; regWrSel = 2'd1; regWrData = 32'h0000_0700;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
    chk("R7 entry wins", flagsOut, 32'h0000_0200);
    wr(2'd1, 32'h0000_0200);

    curTag = "R9";
    cnt(300, 0);
    wr(2'd2, 32'h0000_0401); idle(1);
    chk("R9 line0 on", {30'b0, irqLine1, irqLine0}, 32'h1);
    wr(2'd2, 32'h0000_0406); idle(1);
    chk("R9 line1 on", {30'b0, irqLine1, irqLine0}, 32'h2);
    wr(2'd2, 32'h0000_0106); idle(1);
    chk("R9 flag not enabled", {30'b0, irqLine1, irqLine0}, 32'h0);

    curTag = "R10";
    cnt(10, 300); idle(1);
    chk("R10 rx high is passive", statusOut & 32'h0007_0000, 32'h0002_0000);
    cnt(0, 0);

    curTag = "R4 random";
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom % 8);
      txErrCnt = 9'(vals[$urandom % 12]);
      rxErrCnt = 9'(vals[$urandom % 12]);
      errEvt = ($urandom % 4 == 0) ? 6'($urandom) : 6'b0;
      regWrEn = (r < 3);
      regWrSel = 2'($urandom % 3);
      regWrData = $urandom;
      @(negedge clk);
    end
    regWrEn = 1'b0; errEvt = '0;
    idle(3);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule